// File: doc/BRIEF.md
# Single-Line Flash Command Engine

This block sends one free-form command to a serial flash over a single-data-line SPI link and collects what the flash returns. A host first loads up to eight payload bytes into two 32-bit data registers. It then writes a command strobe that carries the opcode, a length code, two static pin levels, a write-enable flag, a wait-for-idle flag and two long-frame controls. The engine drives chip select, the serial clock and the serial output. It samples the serial input, and the received payload bytes replace the transmitted ones in the same data registers. A one-cycle ready pulse marks the end of the work.

Before the command frame, the engine can send two kinds of frame, each in its own chip-select frame. The first is a status-read loop (opcode 0x05) that repeats while the flash reports a write in progress. The second is a single write-enable frame (opcode 0x06). In long-frame mode one chip-select frame spans several strobes. The opcode goes out only with the first strobe, and every later strobe adds payload bytes only. The frame stays open until a strobe asks for it to close.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCK is low, busy and ready are low, IO2 and IO3 are high, and both data registers read zero.
- R2: A strobe with length code L opens one chip-select frame that carries the opcode and then L-1 payload bytes. Code 0 counts as 1 and codes above 9 count as 9. Bits go out most significant first on IO0 with SCK idle low, and IO0 is held steady while SCK is high.
- R3: Payload byte k, for k from 0 to 7, is taken from bits [8k+7:8k] of the 64-bit value {dat1, dat0}. Bytes 0 to 3 therefore come from dat0, lowest byte first.
- R4: IO1 is sampled on each rising SCK edge, most significant bit first. The byte received during payload slot k is written to byte k of {dat1, dat0}, and bytes beyond the payload count keep their value. Bytes received in the status-read and write-enable frames never reach the data registers.
- R5: IO2 and IO3 take the levels given by the strobe that opens a frame. They do not change while chip select is low.
- R6: When the write-enable flag is set, a frame that holds only the byte 0x06 comes before the command frame.
- R7: When the wait-for-idle flag is set, the engine first sends status frames. Each such frame holds 0x05 followed by one read byte. It sends them again while bit 0 of the read byte is 1, and only then sends any write-enable frame or the command frame.
- R8: busy goes high in the cycle after an accepted strobe. ready is a one-cycle pulse after the command frame or segment ends, and busy is low while ready is high.
- R9: Command strobes and data register writes that arrive while busy is high have no effect.
- R10: A strobe with the long-frame flag set and the stop flag clear leaves chip select low. While a frame stays open, each later strobe sends only L-1 payload bytes, with no opcode, no status or write-enable frames and no change to IO2/IO3. A strobe with the stop flag set, or with the long-frame flag clear, raises chip select at its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Command strobe, one cycle |
| cfg_opcode | input | 8 | Opcode byte |
| cfg_len | input | 4 | Length code: 1 means opcode only, up to 9 |
| cfg_io2 | input | 1 | Static IO2 level for the frame |
| cfg_io3 | input | 1 | Static IO3 level for the frame |
| cfg_wren | input | 1 | Send a write-enable frame first |
| cfg_wipwait | input | 1 | Poll status until not busy first |
| cfg_lfen | input | 1 | Long-frame mode |
| cfg_lfstop | input | 1 | Close the long frame after this strobe |
| dat_we | input | 2 | Write enable for dat1 (bit 1) and dat0 (bit 0) |
| dat_wdata | input | 32 | Data register write value |
| dat0_q | output | 32 | Data register 0: payload bytes 0 to 3 |
| dat1_q | output | 32 | Data register 1: payload bytes 4 to 7 |
| busy | output | 1 | Engine is working |
| ready | output | 1 | One-cycle completion pulse |
| spi_csn | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_io0 | output | 1 | Serial data out |
| spi_io1 | input | 1 | Serial data in |
| spi_io2 | output | 1 | Static level line 2 |
| spi_io3 | output | 1 | Static level line 3 |

## Verification
The bench steps through all sixteen length codes. Each run uses its own opcode, its own 64-bit payload and its own IO2/IO3 pair, so one run covers payload byte order, the clamping of codes 0 and 10 to 15, and which register bytes the response overwrites. The write-enable and status-read prefixes are tried with the flash model reporting busy for none, then for two polls. This shows that the loop depends on bit 0 and that the frames come in the right order. A three-strobe long frame, with conflicting pin levels and prefix flags on the middle strobe, separates the frame-open behaviour from the single-frame case. Strobes and data writes sent mid-transfer show that nothing is accepted while the engine is busy.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMD_LEN_W = 4;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_WR_EN  = 8'h06;

  typedef enum logic [2:0] {ST_IDLE, ST_GAP, ST_LOAD, ST_SHIFT, ST_FIN} eng_state_t;
  typedef enum logic [1:0] {PH_POLL, PH_WREN, PH_MAIN} eng_phase_t;

  typedef struct packed {
    logic [7:0]           opcode;
    logic [CMD_LEN_W-1:0] len;
    logic                 wren;
    logic                 lfen;
    logic                 lfstop;
  } cmd_cfg_t;
endpackage

// File: rtl/fce_bit_shifter.sv
module fce_bit_shifter #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int CW = $clog2(HALF + 1);

  logic          run;
  logic [CW-1:0] tick;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      run  <= 1'b0;
      sck  <= 1'b0;
      mosi <= 1'b0;
      tick <= '0;
      bitn <= '0;
      sh   <= '0;
      rx   <= '0;
    end else if (start) begin
      run  <= 1'b1;
      sh   <= tx;
      mosi <= tx[7];
      tick <= '0;
      bitn <= '0;
      sck  <= 1'b0;
    end else if (run) begin
      if (tick == CW'(HALF - 1)) begin
        tick <= '0;
        if (!sck) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitn == 3'd7) begin
            run  <= 1'b0;
            done <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b0};
            mosi <= sh[6];
          end
        end
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  // IO0 may only move while SCK is low (mode 0 launch)
  assert_io0_hold_R2: assert property (@(posedge clk) disable iff (rst)
    sck |-> $stable(mosi));
endmodule

// File: rtl/fce_data_regs.sv
module fce_data_regs #(
  parameter int WORD_W   = 32,
  parameter int IDX_BITS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_en,
  input  logic [1:0]          host_we,
  input  logic [WORD_W-1:0]   host_wdata,
  input  logic                rx_we,
  input  logic [IDX_BITS-1:0] rx_idx,
  input  logic [7:0]          rx_byte,
  output logic [2*WORD_W-1:0] q
);
  localparam int BPW = WORD_W / 8;
  localparam int NB  = 2 * BPW;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst)
        byte_q <= '0;
      else if (rx_we && rx_idx == IDX_BITS'(b))
        byte_q <= rx_byte;
      else if (host_en && host_we[b / BPW])
        byte_q <= host_wdata[(b % BPW)*8 +: 8];
    end
    assign q[b*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int SCK_HALF = 2,
  parameter int CSN_GAP  = 4,
  parameter int WORD_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_opcode,
  input  logic [CMD_LEN_W-1:0] cfg_len,
  input  logic                 cfg_io2,
  input  logic                 cfg_io3,
  input  logic                 cfg_wren,
  input  logic                 cfg_wipwait,
  input  logic                 cfg_lfen,
  input  logic                 cfg_lfstop,
  input  logic [1:0]           dat_we,
  input  logic [WORD_W-1:0]    dat_wdata,
  output logic [WORD_W-1:0]    dat0_q,
  output logic [WORD_W-1:0]    dat1_q,
  output logic                 busy,
  output logic                 ready,
  output logic                 spi_csn,
  output logic                 spi_sck,
  output logic                 spi_io0,
  input  logic                 spi_io1,
  output logic                 spi_io2,
  output logic                 spi_io3
);
  localparam int MAX_DATA = 2 * WORD_W / 8;
  localparam int IDX_W    = $clog2(MAX_DATA + 2);
  localparam int BI_W     = $clog2(MAX_DATA);
  localparam int GAP_W    = $clog2(CSN_GAP + 1);

  function automatic logic [IDX_W-1:0] payload_count(input logic [CMD_LEN_W-1:0] l);
    if (l == '0)                             return '0;
    else if (l > CMD_LEN_W'(MAX_DATA + 1))   return IDX_W'(MAX_DATA);
    else                                     return IDX_W'(l - 1'b1);
  endfunction

  eng_state_t        st;
  eng_phase_t        ph;
  cmd_cfg_t          cfg_q;
  logic              lf_active, has_op, stat_wip, csn_q, io2_q, io3_q, ready_q;
  logic [IDX_W-1:0]  seg_idx, seg_total;
  logic [GAP_W-1:0]  gap_cnt;
  logic [BI_W-1:0]   didx;
  logic [7:0]        sh_tx, sh_rx;
  logic              sh_start, sh_done, rx_we;
  logic [2*WORD_W-1:0] dat_q;

  assign didx     = BI_W'(seg_idx - IDX_W'(has_op));
  assign sh_start = (st == ST_LOAD);
  assign rx_we    = (st == ST_SHIFT) && sh_done && (ph == PH_MAIN) &&
                    !(has_op && seg_idx == '0);

  always_comb begin
    case (ph)
      PH_POLL: sh_tx = (seg_idx == '0) ? OP_STATUS : 8'h00;
      PH_WREN: sh_tx = OP_WR_EN;
      default: sh_tx = (has_op && seg_idx == '0) ? cfg_q.opcode : dat_q[8*didx +: 8];
    endcase
  end

  always_ff @(posedge clk) begin
    ready_q <= 1'b0;
    if (rst) begin
      st        <= ST_IDLE;
      ph        <= PH_MAIN;
      cfg_q     <= '0;
      lf_active <= 1'b0;
      has_op    <= 1'b0;
      stat_wip  <= 1'b0;
      csn_q     <= 1'b1;
      io2_q     <= 1'b1;
      io3_q     <= 1'b1;
      seg_idx   <= '0;
      seg_total <= '0;
      gap_cnt   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (cfg_we) begin
          if (lf_active) begin
            cfg_q.len    <= cfg_len;
            cfg_q.lfen   <= cfg_lfen;
            cfg_q.lfstop <= cfg_lfstop;
            ph        <= PH_MAIN;
            has_op    <= 1'b0;
            seg_idx   <= '0;
            seg_total <= payload_count(cfg_len);
            st        <= (payload_count(cfg_len) == '0) ? ST_FIN : ST_LOAD;
          end else begin
            cfg_q   <= '{opcode: cfg_opcode, len: cfg_len, wren: cfg_wren,
                         lfen: cfg_lfen, lfstop: cfg_lfstop};
            io2_q   <= cfg_io2;
            io3_q   <= cfg_io3;
            ph      <= cfg_wipwait ? PH_POLL : (cfg_wren ? PH_WREN : PH_MAIN);
            gap_cnt <= '0;
            st      <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_cnt == GAP_W'(CSN_GAP - 1)) begin
            csn_q   <= 1'b0;
            seg_idx <= '0;
            has_op  <= (ph == PH_MAIN);
            case (ph)
              PH_POLL: seg_total <= IDX_W'(2);
              PH_WREN: seg_total <= IDX_W'(1);
              default: seg_total <= IDX_W'(1) + payload_count(cfg_q.len);
            endcase
            st <= ST_LOAD;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_LOAD: st <= ST_SHIFT;
        ST_SHIFT: if (sh_done) begin
          if (ph == PH_POLL && seg_idx == IDX_W'(1)) stat_wip <= sh_rx[0];
          if (seg_idx + 1'b1 == seg_total) st <= ST_FIN;
          else begin
            seg_idx <= seg_idx + 1'b1;
            st      <= ST_LOAD;
          end
        end
        ST_FIN: begin
          case (ph)
            PH_POLL: begin
              csn_q   <= 1'b1;
              gap_cnt <= '0;
              st      <= ST_GAP;
              if (!stat_wip) ph <= cfg_q.wren ? PH_WREN : PH_MAIN;
            end
            PH_WREN: begin
              csn_q   <= 1'b1;
              gap_cnt <= '0;
              ph      <= PH_MAIN;
              st      <= ST_GAP;
            end
            default: begin
              if (cfg_q.lfen && !cfg_q.lfstop) lf_active <= 1'b1;
              else begin
                lf_active <= 1'b0;
                csn_q     <= 1'b1;
              end
              ready_q <= 1'b1;
              st      <= ST_IDLE;
            end
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  fce_bit_shifter #(.HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .tx(sh_tx), .miso(spi_io1),
    .sck(spi_sck), .mosi(spi_io0), .done(sh_done), .rx(sh_rx)
  );

  fce_data_regs #(.WORD_W(WORD_W), .IDX_BITS(BI_W)) u_regs (
    .clk(clk), .rst(rst), .host_en(st == ST_IDLE), .host_we(dat_we),
    .host_wdata(dat_wdata), .rx_we(rx_we), .rx_idx(didx), .rx_byte(sh_rx),
    .q(dat_q)
  );

  assign dat0_q  = dat_q[WORD_W-1:0];
  assign dat1_q  = dat_q[2*WORD_W-1:WORD_W];
  assign busy    = (st != ST_IDLE);
  assign ready   = ready_q;
  assign spi_csn = csn_q;
  assign spi_io2 = io2_q;
  assign spi_io3 = io3_q;

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (rst)
    spi_csn |-> !spi_sck);
  assert_io_static_R5: assert property (@(posedge clk) disable iff (rst)
    (!spi_csn && $past(!spi_csn)) |-> ($stable(spi_io2) && $stable(spi_io3)));
  assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (rst)
    ready |-> !busy);
  assert_busy_lock_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !ready) |=> (busy || ready));
endmodule

// File: tb/flash_cmd_engine_test.sv
module flash_cmd_engine_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic cfg_we = 0, cfg_io2 = 0, cfg_io3 = 0, cfg_wren = 0, cfg_wipwait = 0;
  logic cfg_lfen = 0, cfg_lfstop = 0;
  logic [7:0] cfg_opcode = 0;
  logic [3:0] cfg_len = 0;
  logic [1:0] dat_we = 0;
  logic [31:0] dat_wdata = 0;
  logic [31:0] dat0_q, dat1_q;
  logic busy, ready, spi_csn, spi_sck, spi_io0, spi_io1, spi_io2, spi_io3;

  flash_cmd_engine uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_opcode(cfg_opcode), .cfg_len(cfg_len),
    .cfg_io2(cfg_io2), .cfg_io3(cfg_io3), .cfg_wren(cfg_wren), .cfg_wipwait(cfg_wipwait),
    .cfg_lfen(cfg_lfen), .cfg_lfstop(cfg_lfstop), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .dat0_q(dat0_q), .dat1_q(dat1_q), .busy(busy), .ready(ready), .spi_csn(spi_csn),
    .spi_sck(spi_sck), .spi_io0(spi_io0), .spi_io1(spi_io1), .spi_io2(spi_io2),
    .spi_io3(spi_io3)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  // ---------------- flash model / frame monitor ----------------
  logic [7:0] fbytes [0:2047];
  int         fstart [0:127];
  int         flen   [0:127];
  logic [1:0] fio    [0:127];
  int nf = 0, pos = 0, bitcnt = 0, n_status = 0, wip_until = 0, io_changes = 0;
  logic [7:0] shreg = 0, cur_first = 0;

  function automatic logic [7:0] resp(input int idx);
    return 8'((idx * 37 + 60) & 255);
  endfunction

  always @(posedge spi_sck or posedge spi_csn) begin
    if (spi_csn) begin
      if (bitcnt > 0) begin
        flen[nf] = bitcnt / 8;
        if (cur_first == 8'h05) n_status++;
        nf++;
      end
      bitcnt = 0;
    end else begin
      if (bitcnt == 0) begin
        fstart[nf] = pos;
        fio[nf] = {spi_io2, spi_io3};
      end else if ({spi_io2, spi_io3} != fio[nf]) io_changes++;
      shreg = {shreg[6:0], spi_io0};
      bitcnt++;
      if (bitcnt % 8 == 0) begin
        fbytes[pos] = shreg;
        pos++;
        if (bitcnt == 8) cur_first = shreg;
      end
    end
  end

  logic io1_drv;
  always @* begin
    logic [7:0] rb;
    if (bitcnt < 8) rb = 8'h00;
    else if (cur_first == 8'h05) rb = (n_status < wip_until) ? 8'h03 : 8'h00;
    else rb = resp(bitcnt / 8);
    io1_drv = rb[7 - (bitcnt % 8)];
  end
  assign spi_io1 = io1_drv;

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_frame(input string req, input int fi, input int n, input logic [127:0] eb);
    check({req, " frame length"}, 64'(flen[fi]), 64'(n));
    for (int i = 0; i < n && i < 16; i++)
      check({req, " frame byte"}, 64'(fbytes[fstart[fi] + i]), 64'(eb[8*i +: 8]));
  endtask

  function automatic int clampn(input int l);
    if (l == 0) return 0;
    if (l > 9) return 8;
    return l - 1;
  endfunction

  function automatic logic [63:0] merge_rx(input logic [63:0] p, input int n, input int first);
    logic [63:0] r = p;
    for (int k = 0; k < n; k++) r[8*k +: 8] = resp(first + k);
    return r;
  endfunction

  task automatic wr_dat(input logic [63:0] v);
    @(negedge clk); dat_we = 2'b01; dat_wdata = v[31:0];
    @(negedge clk); dat_we = 2'b10; dat_wdata = v[63:32];
    @(negedge clk); dat_we = 2'b00;
  endtask

  task automatic start_cmd(input logic [7:0] op, input int len, input logic i2, input logic i3,
                           input logic wr, input logic wp, input logic lf, input logic stp);
    @(negedge clk);
    cfg_opcode = op; cfg_len = 4'(len); cfg_io2 = i2; cfg_io3 = i3;
    cfg_wren = wr; cfg_wipwait = wp; cfg_lfen = lf; cfg_lfstop = stp; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R8 busy after accept", 64'(busy), 64'd1);
  endtask

  task automatic wait_ready();
    int t = 0;
    while (!ready && t < 20000) begin @(negedge clk); t++; end
    check("R8 ready seen", 64'(ready), 64'd1);
    check("R8 not busy at ready", 64'(busy), 64'd0);
    @(negedge clk);
    check("R8 ready one cycle", 64'(ready), 64'd0);
  endtask

  task automatic run_cmd(input logic [7:0] op, input int len, input logic i2, input logic i3,
                         input logic wr, input logic wp, input logic lf, input logic stp);
    start_cmd(op, len, i2, i3, wr, wp, lf, stp);
    wait_ready();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [63:0] p, p2, p3;
    logic [127:0] eb;
    int base, ioc, n;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pins", {58'd0, spi_csn, spi_sck, busy, ready, spi_io2, spi_io3}, 64'b100011);
    check("R1 data regs", {dat1_q, dat0_q}, 64'd0);

    // R2 R3 R4 R5: sweep every length code
    for (int L = 0; L < 16; L++) begin
      p = 64'h0123_4567_89AB_CDEF ^ (64'(L) * 64'h1111_0101_2222_0303);
      wr_dat(p);
      check("R3 data write", {dat1_q, dat0_q}, p);
      base = nf; ioc = io_changes; n = clampn(L);
      run_cmd(8'(8'h90 + L), L, L[0], L[1], 0, 0, 0, 0);
      check("R2 one frame", 64'(nf - base), 64'd1);
      eb = '0; eb[7:0] = 8'(8'h90 + L);
      for (int k = 0; k < n; k++) eb[8*(k+1) +: 8] = p[8*k +: 8];
      chk_frame("R2 R3", base, n + 1, eb);
      check("R5 io levels", 64'(fio[base]), {62'd0, L[0], L[1]});
      check("R5 io static", 64'(io_changes - ioc), 64'd0);
      check("R4 rx into regs", {dat1_q, dat0_q}, merge_rx(p, n, 1));
    end

    // R6 write-enable prefix
    p = 64'hA1B2_C3D4_E5F6_0718;
    wr_dat(p); base = nf;
    run_cmd(8'h20, 4, 1, 1, 1, 0, 0, 0);
    check("R6 frame count", 64'(nf - base), 64'd2);
    chk_frame("R6 wren", base, 1, 128'h06);
    eb = {80'd0, p[23:0], 8'h20};
    chk_frame("R6 main", base + 1, 4, eb);

    // R7 status polling with two busy reports, then write enable
    p = 64'h5555_AAAA_3333_CCCC;
    wr_dat(p); base = nf;
    wip_until = n_status + 2;
    run_cmd(8'hD8, 1, 0, 1, 1, 1, 0, 0);
    check("R7 frame count", 64'(nf - base), 64'd5);
    for (int i = 0; i < 3; i++) chk_frame("R7 poll", base + i, 2, 128'h0005);
    chk_frame("R7 wren", base + 3, 1, 128'h06);
    chk_frame("R7 main", base + 4, 1, 128'hD8);
    check("R4 status not stored", {dat1_q, dat0_q}, p);
    // R7 flash already idle: one poll only
    base = nf; wip_until = n_status;
    run_cmd(8'h9E, 1, 0, 0, 0, 1, 0, 0);
    check("R7 idle frame count", 64'(nf - base), 64'd2);
    chk_frame("R7 idle poll", base, 2, 128'h0005);

    // R9 strobes and data writes while busy are ignored
    p = 64'h1357_9BDF_2468_ACE0;
    wr_dat(p); base = nf;
    start_cmd(8'h4B, 3, 0, 0, 0, 0, 0, 0);
    repeat (6) @(negedge clk);
    cfg_opcode = 8'hAA; cfg_len = 4'd9; cfg_we = 1'b1; dat_we = 2'b11; dat_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    cfg_we = 1'b0; dat_we = 2'b00;
    wait_ready();
    repeat (200) @(negedge clk);
    check("R9 no extra frame", 64'(nf - base), 64'd1);
    check("R9 idle after", 64'(busy), 64'd0);
    chk_frame("R9 frame", base, 3, {104'd0, p[15:0], 8'h4B});
    check("R9 data untouched", {dat1_q, dat0_q}, merge_rx(p, 2, 1));

    // R10 long frame over three strobes
    p  = 64'hF0E1_D2C3_B4A5_9687;
    p2 = 64'h1122_3344_5566_7788;
    p3 = 64'h99AA_BBCC_DDEE_FF10;
    wr_dat(p); base = nf; ioc = io_changes;
    run_cmd(8'h9F, 3, 1, 0, 0, 0, 1, 0);
    check("R10 csn held", 64'(spi_csn), 64'd0);
    check("R10 frame open", 64'(nf - base), 64'd0);
    check("R10 rx seg1", {dat1_q, dat0_q}, merge_rx(p, 2, 1));
    wr_dat(p2);
    run_cmd(8'h00, 5, 0, 1, 1, 1, 1, 0);
    check("R10 csn held 2", 64'(spi_csn), 64'd0);
    check("R10 io kept", {62'd0, spi_io2, spi_io3}, 64'b10);
    check("R10 rx seg2", {dat1_q, dat0_q}, merge_rx(p2, 4, 3));
    wr_dat(p3);
    run_cmd(8'h00, 2, 0, 0, 0, 0, 1, 1);
    check("R10 csn released", 64'(spi_csn), 64'd1);
    check("R10 frame closed", 64'(nf - base), 64'd1);
    eb = {64'd0, p3[7:0], p2[31:0], p[15:0], 8'h9F};
    chk_frame("R10 long", base, 8, eb);
    check("R10 io levels", 64'(fio[base]), 64'b10);
    check("R10 io static", 64'(io_changes - ioc), 64'd0);
    check("R10 rx seg3", {dat1_q, dat0_q}, merge_rx(p3, 1, 7));

    // R10 a later strobe starts a fresh frame with an opcode
    base = nf;
    run_cmd(8'h35, 1, 1, 1, 0, 0, 0, 0);
    chk_frame("R10 fresh", base, 1, 128'h35);

    finish_run();
  end
endmodule